// File: doc/BRIEF.md
# Infrared Mark/Space Transmitter

This block plays infrared waveforms from a queue of timed intervals. Software pushes 13-bit interval descriptors into a 128-deep queue through a four-word register window. The block starts an interval as soon as the queue holds one, then takes the next on the same edge the previous one expires. An interval is either a mark, during which a square-wave carrier drives the output, or a space, during which the output rests at the idle level.

The length of each interval is counted in one of four timebases. Three are fixed tick rates derived from a 1 us tick input (1 us, 10 us and 100 us). The fourth is one full carrier period. The carrier high and low lengths are counted in modulator ticks, and a control field picks the source of those ticks. An interrupt output lets software refill the queue in bursts: it is raised when the queue drains down to a programmable level.

Top module: `ir_tx_core`

## Requirements
- R1: A write to word 2 with bit 16 set pushes bits 12:0 as one queue entry. The queue holds DEPTH (128) entries. A push while the queue is full is dropped and sets a sticky overflow flag, status bit 17. Software clears the flag by writing status with bit 17 at 0. Status bits 31:24 read the current queue level.
- R2: In an entry, bit 12 = 1 makes the interval a mark (carrier on the output) and bit 12 = 0 makes it a space (output at the idle level). Bits 11:10 select the timebase and bits 9:0 hold the tick count minus one.
- R3: The carrier word (word 1) holds the low length minus one in bits 31:16 and the high length minus one in bits 15:0. During a mark the output is high for H and low for L modulator ticks in each period.
- R4: Every mark starts at the beginning of the high phase of the carrier, whatever the carrier phase was before.
- R5: An interval lasts (field + 1) ticks of its timebase. Timebase 0 ticks every 1 us, 1 every 10 us, 2 every 100 us, and 3 at the end of every carrier period.
- R6: Control bits 13:12 select the modulator tick: 0 = every clock, 1 = divided-crystal tick input, 2 = 1 us tick, 3 = 10 us tick.
- R7: Entries play back to back in push order with no gap. When the queue is empty the output rests at the idle level.
- R8: Control bit 2 sets the idle level (1 = high). The output shows this level whenever the block is disabled or no mark is playing.
- R9: Status bit 16 (pending) is set when a pop lowers the queue level to the threshold in status bits 7:0. irq_o is high while pending is set and status bit 8 is 1. Writing status with bit 16 at 0 clears pending.
- R10: While control bit 0 (enable) is 0, the queue is kept empty, pushes are discarded without setting overflow, and the output goes idle.
- R11: After reset all registers read 0, ir_o is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word select: 0 control, 1 carrier, 2 queue push, 3 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word (word 2 reads 0) |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| xtal_tick_i | input | 1 | One-cycle pulse at the divided crystal rate |
| ir_o | output | 1 | Modulated infrared drive level |
| irq_o | output | 1 | Queue refill interrupt |

## Verification
The timing state is mostly hidden behind the output. A carrier counter that does not restart shows up at once as a mark whose first high phase is clipped, and the total high time then drifts by part of a period. A wrong interval counter or timebase shows up as an output span that falls outside the bound set by the tick rate within a single interval. Queue state is visible through the level field and through irq_o: a level that is off by one moves the interrupt by one pop, and a missed flush leaves a non-zero level two cycles after enable is cleared.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int DUR_W    = 10;
  localparam int PUSH_BIT = 16;
  localparam int PEND_BIT = 16;
  localparam int OVF_BIT  = 17;
  localparam int IE_BIT   = 8;
  localparam int LVL_LSB  = 24;

  typedef enum logic [1:0] {
    TB_1US   = 2'd0,
    TB_10US  = 2'd1,
    TB_100US = 2'd2,
    TB_CARR  = 2'd3
  } tbase_e;

  typedef enum logic [1:0] {
    MCLK_SYS  = 2'd0,
    MCLK_XTAL = 2'd1,
    MCLK_US   = 2'd2,
    MCLK_10US = 2'd3
  } mclk_e;

  typedef struct packed {
    logic             mark;
    tbase_e           tb;
    logic [DUR_W-1:0] dur;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CARR = 2'd1;
  localparam logic [1:0] A_FIFO = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 13,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_i) wptr_q <= inc(wptr_q);
      if (pop_i)  rptr_q <= inc(rptr_q);
      case ({push_i, pop_i})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign dout_o  = mem[rptr_q];
  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LW'(DEPTH));
  assign level_o = level_q;
endmodule

// File: rtl/irtx_ticks.sv
module irtx_ticks import irtx_pkg::*; #(
  parameter int PRE  = 10,
  localparam int PW  = $clog2(PRE)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  us_tick_i,
  input  logic  xtal_tick_i,
  input  mclk_e mclk_sel_i,
  output logic  t1_o,
  output logic  t10_o,
  output logic  t100_o,
  output logic  mod_tick_o
);
  logic [PW-1:0] div_a_q, div_b_q;
  logic          t10, t100;

  assign t10  = us_tick_i && (div_a_q == PW'(PRE - 1));
  assign t100 = t10 && (div_b_q == PW'(PRE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_a_q <= '0;
      div_b_q <= '0;
    end else if (!en_i) begin
      div_a_q <= '0;
      div_b_q <= '0;
    end else begin
      if (us_tick_i) div_a_q <= t10 ? '0 : div_a_q + 1'b1;
      if (t10)       div_b_q <= t100 ? '0 : div_b_q + 1'b1;
    end
  end

  always_comb begin
    case (mclk_sel_i)
      MCLK_SYS:  mod_tick_o = 1'b1;
      MCLK_XTAL: mod_tick_o = xtal_tick_i;
      MCLK_US:   mod_tick_o = us_tick_i;
      default:   mod_tick_o = t10;
    endcase
  end

  assign t1_o   = us_tick_i;
  assign t10_o  = t10;
  assign t100_o = t100;
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          restart_i,
  input  logic          mod_tick_i,
  input  logic [CW-1:0] hi_m1_i,
  input  logic [CW-1:0] lo_m1_i,
  output logic          high_o,
  output logic          period_end_o
);
  logic          hi_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b1;
      cnt_q <= '0;
    end else if (!en_i || restart_i) begin
      hi_q  <= 1'b1;
      cnt_q <= '0;
    end else if (mod_tick_i) begin
      if (hi_q) begin
        if (cnt_q >= hi_m1_i) begin
          hi_q  <= 1'b0;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
      end else begin
        if (cnt_q >= lo_m1_i) begin
          hi_q  <= 1'b1;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign high_o       = hi_q;
  assign period_end_o = en_i && mod_tick_i && !hi_q && (cnt_q >= lo_m1_i);
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq import irtx_pkg::*; (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   empty_i,
  input  entry_t head_i,
  input  logic   t1_i,
  input  logic   t10_i,
  input  logic   t100_i,
  input  logic   tper_i,
  output logic   pop_o,
  output logic   restart_o,
  output logic   mark_on_o
);
  logic             active_q;
  entry_t           cur_q;
  logic [DUR_W-1:0] cnt_q;
  logic             tick, done;

  always_comb begin
    case (cur_q.tb)
      TB_1US:   tick = t1_i;
      TB_10US:  tick = t10_i;
      TB_100US: tick = t100_i;
      default:  tick = tper_i;
    endcase
  end

  assign done      = active_q && tick && (cnt_q == cur_q.dur);
  assign pop_o     = en_i && !empty_i && (!active_q || done);
  assign restart_o = pop_o && head_i.mark;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cur_q    <= '0;
      cnt_q    <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (pop_o) begin
      active_q <= 1'b1;
      cur_q    <= head_i;
      cnt_q    <= '0;
    end else if (done) begin
      active_q <= 1'b0;
    end else if (active_q && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mark_on_o = active_q && cur_q.mark;
endmodule

// File: rtl/ir_tx_core.sv
module ir_tx_core import irtx_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int CW    = 16,
  parameter int PRE   = 10,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        us_tick_i,
  input  logic        xtal_tick_i,
  output logic        ir_o,
  output logic        irq_o
);
  logic          en_q, init_q, ie_q, pend_q, ovf_q;
  mclk_e         mclk_q;
  logic [CW-1:0] hi_m1_q, lo_m1_q;
  logic [LW-1:0] thr_q;

  logic          wr_ctrl, wr_carr, wr_stat, push_req, push_acc, push_drop, pend_set;
  logic          pop, restart, mark_on, empty, full;
  logic [LW-1:0] level;
  entry_t        head;
  logic          t1, t10, t100, mod_tick, car_high, car_pend;
  wire           unused_wdata = ^reg_wdata_i;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_carr   = reg_we_i && (reg_addr_i == A_CARR);
  assign wr_stat   = reg_we_i && (reg_addr_i == A_STAT);
  assign push_req  = reg_we_i && (reg_addr_i == A_FIFO) && reg_wdata_i[PUSH_BIT];
  assign push_acc  = push_req && en_q && !full;
  assign push_drop = push_req && en_q && full;
  // queue level falls onto the threshold through a pop
  assign pend_set  = pop && !push_acc && ({1'b0, level} == {1'b0, thr_q} + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      init_q  <= 1'b0;
      mclk_q  <= MCLK_SYS;
      hi_m1_q <= '0;
      lo_m1_q <= '0;
      thr_q   <= '0;
      ie_q    <= 1'b0;
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= reg_wdata_i[0];
        init_q <= reg_wdata_i[2];
        mclk_q <= mclk_e'(reg_wdata_i[13:12]);
      end
      if (wr_carr) begin
        hi_m1_q <= reg_wdata_i[CW-1:0];
        lo_m1_q <= reg_wdata_i[16 +: CW];
      end
      if (wr_stat) begin
        thr_q <= reg_wdata_i[LW-1:0];
        ie_q  <= reg_wdata_i[IE_BIT];
      end
      if (pend_set) pend_q <= 1'b1;
      else if (wr_stat && !reg_wdata_i[PEND_BIT]) pend_q <= 1'b0;
      if (push_drop) ovf_q <= 1'b1;
      else if (wr_stat && !reg_wdata_i[OVF_BIT]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[0]     = en_q;
        reg_rdata_o[2]     = init_q;
        reg_rdata_o[13:12] = mclk_q;
      end
      A_CARR: begin
        reg_rdata_o[CW-1:0]  = hi_m1_q;
        reg_rdata_o[16 +: CW] = lo_m1_q;
      end
      A_STAT: begin
        reg_rdata_o[LW-1:0]         = thr_q;
        reg_rdata_o[IE_BIT]         = ie_q;
        reg_rdata_o[PEND_BIT]       = pend_q;
        reg_rdata_o[OVF_BIT]        = ovf_q;
        reg_rdata_o[LVL_LSB +: LW]  = level;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  irtx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (!en_q),
    .push_i  (push_acc),
    .din_i   (reg_wdata_i[ENTRY_W-1:0]),
    .pop_i   (pop),
    .dout_o  (head),
    .empty_o (empty),
    .full_o  (full),
    .level_o (level)
  );

  irtx_ticks #(.PRE(PRE)) u_ticks (
    .clk_i, .rst_ni,
    .en_i        (en_q),
    .us_tick_i,
    .xtal_tick_i,
    .mclk_sel_i  (mclk_q),
    .t1_o        (t1),
    .t10_o       (t10),
    .t100_o      (t100),
    .mod_tick_o  (mod_tick)
  );

  irtx_carrier #(.CW(CW)) u_car (
    .clk_i, .rst_ni,
    .en_i         (en_q),
    .restart_i    (restart),
    .mod_tick_i   (mod_tick),
    .hi_m1_i      (hi_m1_q),
    .lo_m1_i      (lo_m1_q),
    .high_o       (car_high),
    .period_end_o (car_pend)
  );

  irtx_seq u_seq (
    .clk_i, .rst_ni,
    .en_i      (en_q),
    .empty_i   (empty),
    .head_i    (head),
    .t1_i      (t1),
    .t10_i     (t10),
    .t100_i    (t100),
    .tper_i    (car_pend),
    .pop_o     (pop),
    .restart_o (restart),
    .mark_on_o (mark_on)
  );

  assign ir_o  = mark_on ? car_high : init_q;
  assign irq_o = pend_q && ie_q;
endmodule

// File: rtl/irtx_checker.sv
module irtx_checker #(
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          init_i,
  input logic          pend_i,
  input logic [LW-1:0] thr_i,
  input logic [LW-1:0] level_i,
  input logic          ir_i,
  input logic          mark_on_i
);
  AST_LEVEL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LW'(DEPTH)); // R1

  AST_FLUSH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> level_i == '0); // R10

  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> ir_i == init_i); // R8

  AST_PEND_AT_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_i) |-> level_i == thr_i); // R9

  AST_MARK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mark_on_i) |-> ir_i); // R4
endmodule

bind ir_tx_core irtx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_q),
  .init_i    (init_q),
  .pend_i    (pend_q),
  .thr_i     (thr_q),
  .level_i   (level),
  .ir_i      (ir_o),
  .mark_on_i (mark_on)
);

// File: tb/ir_tx_core_test.sv
module ir_tx_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        us_tick = 1'b0, xtal_tick = 1'b0;
  logic        ir, irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  ir_tx_core uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .us_tick_i(us_tick),
    .xtal_tick_i(xtal_tick), .ir_o(ir), .irq_o(irq)
  );

  always #10 clk = ~clk;

  // tick sources and output monitor, all on the falling edge
  int cyc = 0;
  bit meas = 0;
  int highs, rises, first_hi, last_hi;
  int rise_t [8];
  bit prev_ir = 0;
  always @(negedge clk) begin
    cyc++;
    us_tick   = (cyc % 5 == 0);
    xtal_tick = (cyc % 3 == 0);
    if (meas) begin
      if (ir) begin
        highs++;
        if (first_hi < 0) first_hi = cyc;
        last_hi = cyc;
        if (!prev_ir) begin
          if (rises < 8) rise_t[rises] = cyc;
          rises++;
        end
      end
    end
    prev_ir = ir;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas_start();
    highs = 0; rises = 0; first_hi = -1; last_hi = -1;
    meas = 1;
  endtask

  function automatic logic [31:0] ent(input bit mark, input int tb, input int durm1);
    return (32'd1 << 16) | (32'(mark) << 12) | (32'(tb) << 10) | 32'(durm1);
  endfunction

  function automatic logic [31:0] carr(input int h, input int l);
    return (32'(l - 1) << 16) | 32'(h - 1);
  endfunction

  function automatic int exp_span(input int p, input int q, input int r, input int h, input int l);
    return (p + q + r - 1) * (h + l) + h;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R11 reset state
    chk(ir == 1'b0, "R11 ir", ir, 0);
    chk(irq == 1'b0, "R11 irq", irq, 0);
    rd(2'd3, d); chk(d == 0, "R11 status", d, 0);
    rd(2'd0, d); chk(d == 0, "R11 ctrl", d, 0);
    @(negedge clk);

    // R3 register readback
    wr(2'd1, carr(3, 5));
    rd(2'd1, d); chk(d == 32'h0004_0002, "R3 carrier readback", d, 32'h0004_0002);
    @(negedge clk);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk(d == 32'h1, "R6 ctrl readback", d, 1);
    @(negedge clk);

    // R2 R3 R4 R5 R7: random mark/space/mark in carrier-period timebase
    for (int it = 0; it < 8; it++) begin
      int h = 1 + $urandom % 6, l = 1 + $urandom % 6;
      int p = 1 + $urandom % 4, q = 1 + $urandom % 4, r = 1 + $urandom % 4;
      wr(2'd1, carr(h, l));
      idle(2 + $urandom % 7);
      meas_start();
      wr(2'd2, ent(1, 3, p - 1));
      wr(2'd2, ent(0, 3, q - 1));
      wr(2'd2, ent(1, 3, r - 1));
      idle(220);
      meas = 0;
      chk(highs == (p + r) * h, "R3 R4 high cycles", highs, (p + r) * h);
      chk(rises == p + r, "R2 carrier periods", rises, p + r);
      chk(last_hi - first_hi + 1 == exp_span(p, q, r, h, l), "R5 R7 span",
          last_hi - first_hi + 1, exp_span(p, q, r, h, l));
      chk(ir == 1'b0, "R7 idle after empty", ir, 0);
    end

    // R5 fixed timebases, carrier one clock high / one low
    wr(2'd1, carr(1, 1));
    meas_start(); wr(2'd2, ent(1, 0, 6)); idle(60); meas = 0;
    chk(last_hi - first_hi + 1 >= 30 && last_hi - first_hi + 1 <= 35, "R5 1us span",
        last_hi - first_hi + 1, 35);
    meas_start(); wr(2'd2, ent(1, 1, 2)); idle(200); meas = 0;
    chk(last_hi - first_hi + 1 >= 100 && last_hi - first_hi + 1 <= 150, "R5 10us span",
        last_hi - first_hi + 1, 150);
    meas_start(); wr(2'd2, ent(1, 2, 1)); idle(1100); meas = 0;
    chk(last_hi - first_hi + 1 >= 500 && last_hi - first_hi + 1 <= 1000, "R5 100us span",
        last_hi - first_hi + 1, 1000);

    // R6 modulator clock select: period between 2nd and 3rd rise
    wr(2'd1, carr(2, 2));
    wr(2'd0, 32'h1 | (32'd1 << 12));
    meas_start(); wr(2'd2, ent(1, 3, 3)); idle(80); meas = 0;
    chk(rises == 4, "R6 xtal rises", rises, 4);
    chk(rise_t[2] - rise_t[1] == 12, "R6 xtal period", rise_t[2] - rise_t[1], 12);
    wr(2'd0, 32'h1 | (32'd2 << 12));
    meas_start(); wr(2'd2, ent(1, 3, 3)); idle(120); meas = 0;
    chk(rise_t[2] - rise_t[1] == 20, "R6 us period", rise_t[2] - rise_t[1], 20);

    // R8 idle level
    wr(2'd0, 32'h4);
    idle(3);
    chk(ir == 1'b1, "R8 idle high disabled", ir, 1);
    wr(2'd0, 32'h5);
    wr(2'd1, carr(1, 1));
    wr(2'd2, ent(1, 3, 1));
    idle(10);
    chk(ir == 1'b1, "R8 idle high after mark", ir, 1);
    wr(2'd0, 32'h1);

    // R9 threshold interrupt
    wr(2'd3, (32'd1 << 8) | 32'd2);
    wr(2'd2, ent(0, 2, 3));
    idle(2);
    for (int k = 0; k < 4; k++) wr(2'd2, ent(0, 0, 0));
    idle(5);
    chk(irq == 1'b0, "R9 no irq above threshold", irq, 0);
    idle(2200);
    chk(irq == 1'b1, "R9 irq at threshold", irq, 1);
    rd(2'd3, d); chk(d[16] == 1'b1, "R9 pending bit", d[16], 1);
    @(negedge clk);
    wr(2'd3, (32'd1 << 8) | 32'd2);
    idle(1);
    chk(irq == 1'b0, "R9 clear by write", irq, 0);
    wr(2'd3, 32'd0);
    wr(2'd2, ent(0, 0, 0));
    idle(20);
    rd(2'd3, d); chk(d[16] == 1'b1, "R9 pending at zero", d[16], 1);
    chk(irq == 1'b0, "R9 masked irq", irq, 0);
    @(negedge clk);
    wr(2'd3, 32'd0);

    // R1 overflow and level
    wr(2'd2, ent(0, 2, 3));
    idle(2);
    for (int k = 0; k < 129; k++) wr(2'd2, ent(0, 0, 0));
    idle(2);
    rd(2'd3, d);
    chk(d[31:24] == 8'd128, "R1 full level", d[31:24], 128);
    chk(d[17] == 1'b1, "R1 overflow flag", d[17], 1);
    @(negedge clk);

    // R10 disable flushes, pushes dropped
    wr(2'd0, 32'h0);
    idle(2);
    rd(2'd3, d); chk(d[31:24] == 8'd0, "R10 flushed", d[31:24], 0);
    @(negedge clk);
    wr(2'd2, ent(1, 3, 0));
    idle(1);
    rd(2'd3, d); chk(d[31:24] == 8'd0, "R10 push dropped", d[31:24], 0);
    @(negedge clk);
    wr(2'd3, 32'd0);
    rd(2'd3, d); chk(d[17] == 1'b0, "R1 overflow cleared", d[17], 0);
    @(negedge clk);
    wr(2'd0, 32'h1);
    meas_start(); idle(100); meas = 0;
    chk(highs == 0, "R10 quiet after re-enable", highs, 0);

    summary();
  end
endmodule